// File: doc/BRIEF.md
# Charger Fault-Status Register Slave

This block is a two-wire serial slave for a battery charger controller. It holds a sticky status register and a configuration register. Three event inputs from the charger's detectors feed the status register: output over-voltage, thermal shutdown and input under-voltage. The inputs are already synchronized, and each event latches its own status bit. Over-voltage is a fault and pulls an active-low open-drain fault flag. The other two events are warnings and only set their bits. When a host reads the status register, every bit clears. The flag lets go once no fault bit is left.

SCL and SDA are sampled by the system clock through a two-stage synchronizer. The clock must run at 8 MHz or more. SDA is an output-enable only: when `sda_oe` is high the pad pulls the line low, and otherwise the line floats high. The block detects START and STOP, matches the device address, takes a register subaddress, and auto-increments across both reads and writes. It drives ACK after every byte it receives. This is control logic with no data stream, so no port uses a valid/ready handshake and there is no back-pressure. The block never stretches the clock; the master owns the bus timing.

Top module: `chg_status_i2c`

## Requirements
- R1: The slave acknowledges only the 7-bit device address 0x48, sent MSB first with the read/not-write bit last (0 = write). Any other address gets no ACK, and the rest of that transaction changes nothing.
- R2: The status register sits at subaddress 0x00. Bit 7 is over-voltage, bit 3 is thermal shutdown and bit 1 is input under-voltage. Every other bit reads as 0.
- R3: An over-voltage event sets its bit and raises `flt_oe`, which drives the fault flag low. A thermal or under-voltage event sets only its own bit and leaves `flt_oe` unchanged.
- R4: A read of the status register clears all of its bits. `flt_oe` drops once no fault bit is set.
- R5: An event that arrives in the same cycle as a clearing status read stays latched, so it is never lost.
- R6: The configuration register is at subaddress 0x04. It holds a read/write 4-bit maximum charge current in bits 7:4, and that field appears on `ichg_max`. Bits 3:0 read as 0.
- R7: The subaddress space is 0x00–0x1F. Writes to the status register or to any unimplemented location are acknowledged but have no effect. Reads of unimplemented locations return 0x00.
- R8: Each further data byte in one transaction moves the subaddress up by one, for both writes and reads.
- R9: The slave changes SDA only after a falling edge of SCL. During a read, a master NACK after a byte ends the transfer, and the slave releases SDA.
- R10: A STOP releases SDA at once and aborts any byte in progress. A START or repeated START restarts address reception in any state.
- R11: After reset, `sda_oe` and `flt_oe` are low and `ichg_max` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| ev_ovp | input | 1 | Output over-voltage event (fault) |
| ev_tsd | input | 1 | Thermal shutdown event (warning) |
| ev_uvlo | input | 1 | Input under-voltage event (warning) |
| flt_oe | output | 1 | 1 pulls the active-low fault flag low |
| ichg_max | output | 4 | Maximum charge current setting |

## Verification
The hardest case is an over-voltage pulse that lands exactly in the cycle where a status read loads and clears the register. The bench sweeps the pulse across every cycle of the address ACK clock. After each position it reads twice and expects the bit in one of the two reads. If the clear overrode the set, the bit would be missing from both. Warnings are checked on `flt_oe`, because a design that ORed every bit into the flag would pull it low. The auto-increment run crosses an unimplemented location, the configuration register and another gap, so a pointer that fails to advance, or advances twice, returns the wrong byte. A STOP in the middle of a byte, a wrong address and a final NACK each check that SDA is released and that no write leaks through.

// File: rtl/chg_status_pkg.sv
package chg_status_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_SUB, ST_WR, ST_RD} i2c_st_e;
  localparam int OVP_BIT = 7;
  localparam int TSD_BIT = 3;
  localparam int UV_BIT  = 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_ff[0] <= 1'b1; sda_ff[0] <= 1'b1; end
        else begin scl_ff[0] <= scl_in; sda_ff[0] <= sda_in; end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin scl_ff[g] <= 1'b1; sda_ff[g] <= 1'b1; end
        else begin scl_ff[g] <= scl_ff[g-1]; sda_ff[g] <= sda_ff[g-1]; end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= scl_s; sda_q <= sda_s; end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
  import chg_status_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int SUB_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic [SUB_W-1:0] reg_addr,
  output logic [7:0]       wr_data
);
  i2c_st_e          state, nxt_st;
  logic [3:0]       bcnt;
  logic [7:0]       shreg;
  logic [SUB_W-1:0] ptr;
  logic             ack_pend;
  logic [7:0]       byte_in;

  assign byte_in  = {shreg[6:0], sda_s};
  assign reg_addr = ptr;
  assign wr_data  = byte_in;
  assign wr_stb   = scl_rise && state == ST_WR && bcnt == 4'd7;
  assign rd_stb   = scl_rise && bcnt == 4'd8 &&
                    ((state == ST_DEV && nxt_st == ST_RD) || (state == ST_RD && !sda_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; nxt_st <= ST_IDLE; bcnt <= '0; shreg <= '0;
      ptr <= '0; ack_pend <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      state <= ST_DEV; bcnt <= '0; sda_oe <= 1'b0; ack_pend <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; bcnt <= '0; sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        ST_DEV, ST_SUB, ST_WR: begin
          if (bcnt != 4'd8) begin
            shreg <= byte_in;
            bcnt  <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              ack_pend <= 1'b1;
              nxt_st   <= ST_WR;
              if (state == ST_DEV) begin
                if (byte_in[7:1] == DEV_ADDR) nxt_st <= byte_in[0] ? ST_RD : ST_SUB;
                else begin ack_pend <= 1'b0; nxt_st <= ST_IDLE; end
              end else if (state == ST_SUB) ptr <= byte_in[SUB_W-1:0];
              else ptr <= ptr + 1'b1;
            end
          end else begin
            bcnt  <= '0;
            state <= nxt_st;
            if (nxt_st == ST_RD && state == ST_DEV) begin
              shreg <= rd_data;
              ptr   <= ptr + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (bcnt != 4'd8) bcnt <= bcnt + 4'd1;
          else if (!sda_s) begin
            bcnt <= '0; shreg <= rd_data; ptr <= ptr + 1'b1;
          end else state <= ST_IDLE;
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        ST_DEV, ST_SUB, ST_WR: sda_oe <= (bcnt == 4'd8) ? ack_pend : 1'b0;
        ST_RD: begin
          if (bcnt != 4'd8) begin
            sda_oe <= ~shreg[7];
            shreg  <= {shreg[6:0], 1'b0};
          end else sda_oe <= 1'b0;
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/chg_status_regs.sv
module chg_status_regs
  import chg_status_pkg::*;
#(
  parameter int SUB_W = 5,
  parameter int unsigned CFG_ADDR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ovp,
  input  logic             ev_tsd,
  input  logic             ev_uvlo,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [SUB_W-1:0] reg_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [3:0]       ichg_max,
  output logic             flt_oe
);
  logic sts_ovp, sts_tsd, sts_uv, clr;
  logic [7:0] sts_byte;
  logic unused_lo;

  assign unused_lo = ^wr_data[3:0];
  assign clr = rd_stb && reg_addr == '0;

  // a new event wins over the clear in the same cycle
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_ovp <= 1'b0; sts_tsd <= 1'b0; sts_uv <= 1'b0; ichg_max <= '0;
    end else begin
      sts_ovp <= ev_ovp  | (sts_ovp & ~clr);
      sts_tsd <= ev_tsd  | (sts_tsd & ~clr);
      sts_uv  <= ev_uvlo | (sts_uv  & ~clr);
      if (wr_stb && reg_addr == SUB_W'(CFG_ADDR)) ichg_max <= wr_data[7:4];
    end

  always_comb begin
    sts_byte = '0;
    sts_byte[OVP_BIT] = sts_ovp;
    sts_byte[TSD_BIT] = sts_tsd;
    sts_byte[UV_BIT]  = sts_uv;
    if (reg_addr == '0) rd_data = sts_byte;
    else if (reg_addr == SUB_W'(CFG_ADDR)) rd_data = {ichg_max, 4'b0000};
    else rd_data = 8'h00;
  end

  assign flt_oe = sts_ovp;
endmodule

// File: rtl/chg_status_i2c.sv
module chg_status_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int SUB_W = 5,
  parameter int unsigned CFG_ADDR = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       ev_ovp,
  input  logic       ev_tsd,
  input  logic       ev_uvlo,
  output logic       flt_oe,
  output logic [3:0] ichg_max
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rd_stb, wr_stb;
  logic [SUB_W-1:0] reg_addr;
  logic [7:0] rd_data, wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det));

  i2c_slave_ctl #(.DEV_ADDR(DEV_ADDR), .SUB_W(SUB_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .reg_addr(reg_addr), .wr_data(wr_data));

  chg_status_regs #(.SUB_W(SUB_W), .CFG_ADDR(CFG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev_ovp(ev_ovp), .ev_tsd(ev_tsd),
    .ev_uvlo(ev_uvlo), .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .ichg_max(ichg_max), .flt_oe(flt_oe));
endmodule

// File: rtl/chg_status_i2c_chk.sv
module chg_status_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_ovp,
  input logic       flt_oe,
  input logic       sda_oe,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic [3:0] ichg_max
);
  assert_event_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovp |=> flt_oe);
  assert_no_spurious_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_oe && !ev_ovp) |=> !flt_oe);
  assert_sda_drive_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  assert_sda_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_cfg_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scl_rise) |-> $stable(ichg_max));
endmodule

bind chg_status_i2c chg_status_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ovp(ev_ovp), .flt_oe(flt_oe), .sda_oe(sda_oe),
  .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .ichg_max(ichg_max));

// File: tb/test_chg_status_i2c.sv
module test_chg_status_i2c;
  localparam int Q = 8;
  localparam int NV = 7;
  // {subaddress, write data, expected read-back}
  localparam logic [23:0] VEC [NV] = '{
    24'h04_A5_A0, 24'h04_3C_30, 24'h07_FF_00, 24'h1F_12_00,
    24'h04_FF_F0, 24'h00_FF_00, 24'h04_00_00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ev_ovp = 1'b0, ev_tsd = 1'b0, ev_uvlo = 1'b0;
  logic sda_oe, flt_oe;
  logic [3:0] ichg_max;
  wire sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0;

  chg_status_i2c i_chg_status_i2c (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .ev_ovp(ev_ovp), .ev_tsd(ev_tsd), .ev_uvlo(ev_uvlo),
    .flt_oe(flt_oe), .ichg_max(ichg_max));

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bit_cyc(input logic b, output logic s, input int pulse_at);
    sda_m = b; wait_clk(Q); scl_m = 1'b1;
    if (pulse_at >= 0) begin
      wait_clk(pulse_at); ev_ovp = 1'b1; wait_clk(1); ev_ovp = 1'b0;
      wait_clk(2*Q - pulse_at - 1);
    end else wait_clk(2*Q);
    s = sda_line; scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q); scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_clk(Q); scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack, input int pulse_at);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s, -1);
    bit_cyc(1'b1, s, pulse_at);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_cyc(1'b1, s, -1); d[i] = s; end
    bit_cyc(~m_ack, s, -1);
  endtask

  task automatic wr_txn(input logic [7:0] sub, input logic [7:0] data, output logic ack);
    logic a;
    i2c_start(); wr_byte(8'h90, a, -1); wr_byte(sub, a, -1); wr_byte(data, ack, -1);
    i2c_stop();
  endtask

  task automatic rd_txn(input logic [7:0] sub, output logic [7:0] d, input int pulse_at);
    logic a;
    i2c_start(); wr_byte(8'h90, a, -1); wr_byte(sub, a, -1);
    i2c_start(); wr_byte(8'h91, a, pulse_at); rd_byte(1'b0, d);
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-R act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, v1, v2, dd[3];
    logic ack;
    logic [3:0] cfg_exp = 4'h0;
    wait_clk(5); rst_n = 1'b1; wait_clk(2);
    check("R11 sda_oe", sda_oe, 0);
    check("R11 flt_oe", flt_oe, 0);
    check("R11 ichg_max", ichg_max, 0);

    // table: write then read back
    for (int i = 0; i < NV; i++) begin
      wr_txn(VEC[i][23:16], VEC[i][15:8], ack);
      check("R7 data ack", ack, 1);
      if (VEC[i][23:16] == 8'h04) cfg_exp = VEC[i][15:12];
      check("R6 ichg_max", ichg_max, cfg_exp);
      rd_txn(VEC[i][23:16], d, -1);
      check(VEC[i][23:16] == 8'h04 ? "R6 readback" : "R7 readback", d, VEC[i][7:0]);
    end

    // wrong device address
    i2c_start(); wr_byte(8'h92, ack, -1);
    check("R1 foreign addr ack", ack, 0);
    wr_byte(8'h04, ack, -1); wr_byte(8'h70, ack, -1);
    check("R1 sda_oe after foreign", sda_oe, 0);
    i2c_stop();
    check("R1 cfg unchanged", ichg_max, 0);

    // warnings
    ev_tsd = 1'b1; wait_clk(1); ev_tsd = 1'b0; wait_clk(2);
    check("R3 tsd no flag", flt_oe, 0);
    rd_txn(8'h00, d, -1); check("R2 tsd bit", d, 8'h08);
    rd_txn(8'h00, d, -1); check("R4 cleared", d, 8'h00);
    ev_uvlo = 1'b1; wait_clk(1); ev_uvlo = 1'b0; wait_clk(2);
    check("R3 uv no flag", flt_oe, 0);
    rd_txn(8'h00, d, -1); check("R2 uv bit", d, 8'h02);

    // fault
    ev_ovp = 1'b1; wait_clk(1); ev_ovp = 1'b0; wait_clk(2);
    check("R3 ovp flag", flt_oe, 1);
    rd_txn(8'h00, d, -1); check("R2 ovp bit", d, 8'h80);
    check("R4 flag released", flt_oe, 0);
    rd_txn(8'h00, d, -1); check("R4 cleared after fault", d, 8'h00);

    // all three
    ev_ovp = 1'b1; ev_tsd = 1'b1; ev_uvlo = 1'b1; wait_clk(1);
    ev_ovp = 1'b0; ev_tsd = 1'b0; ev_uvlo = 1'b0; wait_clk(2);
    rd_txn(8'h00, d, -1); check("R2 all bits", d, 8'h8A);
    check("R4 flag after all", flt_oe, 0);

    // event pulse swept over the clearing read
    for (int p = 0; p < 2*Q; p++) begin
      rd_txn(8'h00, v1, p);
      rd_txn(8'h00, v2, -1);
      check("R5 event kept", int'(v1 | v2), 8'h80);
    end
    check("R4 flag after sweep", flt_oe, 0);

    // auto-increment write 03,04,05 then read back with final NACK
    i2c_start(); wr_byte(8'h90, ack, -1); wr_byte(8'h03, ack, -1);
    wr_byte(8'h11, ack, -1); wr_byte(8'h22, ack, -1); wr_byte(8'h33, ack, -1);
    check("R8 last write ack", ack, 1);
    i2c_stop();
    check("R8 write increments", ichg_max, 2);
    i2c_start(); wr_byte(8'h90, ack, -1); wr_byte(8'h03, ack, -1);
    i2c_start(); wr_byte(8'h91, ack, -1);
    check("R10 repeated start ack", ack, 1);
    rd_byte(1'b1, dd[0]); rd_byte(1'b1, dd[1]); rd_byte(1'b0, dd[2]);
    check("R9 released after nack", sda_oe, 0);
    i2c_stop();
    check("R8 read 03", dd[0], 8'h00);
    check("R8 read 04", dd[1], 8'h20);
    check("R8 read 05", dd[2], 8'h00);

    // STOP in the middle of a data byte
    i2c_start(); wr_byte(8'h90, ack, -1); wr_byte(8'h04, ack, -1);
    for (int i = 0; i < 4; i++) begin logic s; bit_cyc(1'b1, s, -1); end
    i2c_stop();
    check("R10 stop releases", sda_oe, 0);
    check("R10 aborted write", ichg_max, 2);
    rd_txn(8'h04, d, -1); check("R10 restart after stop", d, 8'h20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule